// File: doc/BRIEF.md
# Warp Issue and Pipe Dispatch Scheduler

This block is the issue stage of one sub-partition of a SIMT processor. In each cycle it looks at a small pool of warps and picks at most one. A warp can be picked when it is active, is not stalled, and the execution resource needed by its next instruction can take it. The chosen instruction is then steered by its class. Math work goes to a heavy FMA pipe, a light FMA pipe or a matrix pipe. Long-latency work is pushed into a variable-latency queue that feeds a shared dispatcher.

A pipe narrower than the 32-lane warp takes one warp instruction over several consecutive beats, and it cannot accept new work until those beats are done. The block keeps a beat counter for each pipe. The light FMA pipe is the first choice for single-precision FMA, which leaves the heavy pipe free for integer multiply-add, the class that only the heavy pipe can run. A paired half-precision instruction uses both FMA pipes in the same cycle. A build-time switch makes paired-half and matrix work share one dispatch port, so that either class blocks the other for as many beats as its dispatch lasts.

Among eligible warps, selection is round-robin and starts at the warp after the last one that issued. A warp that cannot go this cycle never holds up the others. The issue decision is combinational from the current inputs and the registered pipe and pointer state.

Top module: `warp_issue_sched`

## Requirements
- R1: At most one warp issues per cycle, and only a warp that is active and not stalled. When nothing issues, `issue_valid` is 0 and `disp` is 0.
- R2: `disp` bit 0 is the heavy FMA pipe, bit 1 the light FMA pipe, bit 2 the matrix pipe and bit 3 the variable-latency queue. Class code 0 (FP32) goes to the light pipe (`disp`=0010) if that pipe is free, otherwise to the heavy pipe (0001). It waits if both pipes are busy.
- R3: Class code 1 (integer multiply-add) goes only to the heavy pipe (`disp`=0001), and only when that pipe is free.
- R4: Class code 2 (paired half precision) sets both FMA bits (`disp`=0011). It issues only when both FMA pipes are free.
- R5: Class code 3 (matrix) goes to the matrix pipe (`disp`=0100) when that pipe is free.
- R6: Class code 4 (variable latency) goes to the queue (`disp`=1000) only while `vq_full` is 0. Codes 5 to 7 never issue.
- R7: A pipe of width L stays busy for WARP_LANES/L cycles, counting the cycle in which work is dispatched to it. With the default 16-lane pipes, work dispatched to a pipe in cycle t means nothing is dispatched to that pipe in cycle t+1.
- R8: A warp that is blocked by a busy pipe or a full queue does not stop another eligible warp from issuing in the same cycle.
- R9: The search for an eligible warp starts at the warp after the last one that issued and wraps around. After reset, warp 0 has first priority.
- R10: With SHARED_PORT=1, paired-half and matrix instructions share one port. The port stays busy for the beat count of the instruction that used it, and it blocks both classes while busy. With SHARED_PORT=0 the two classes are independent.
- R11: Instructions of different classes may issue in consecutive cycles to different free pipes. For example, integer multiply-add in one cycle can be followed by matrix in the next.
- R12: While `rst_n` is low, `issue_valid` and `disp` are 0. Reset clears every pipe counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| warp_active | input | NUM_WARPS | Warp is resident and active |
| warp_stall | input | NUM_WARPS | Warp is stalled for reasons outside this block |
| warp_class | input | 3*NUM_WARPS | Class code of each warp's next instruction, warp w in bits [3w+2:3w] |
| vq_full | input | 1 | Variable-latency queue cannot take an entry |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_warp | output | $clog2(NUM_WARPS) | Index of the issuing warp |
| disp | output | 4 | Destination vector: heavy, light, matrix, queue |

## Verification
The bench aims at the cycle right after a multi-beat dispatch. A design that counted beats off by one would re-issue to a busy pipe there, or leave a free pipe idle for an extra cycle. It sends FP32 work while only the light pipe is busy, to catch a router that stalls instead of falling back to the heavy pipe. It sends paired-half work while only one FMA pipe is free, which a wrong design would issue half-dispatched. Two instances, with and without the shared port, get the same matrix-after-paired-half sequences. It also holds some warps blocked on a full queue or a busy pipe while others are ready. This catches a design that blocks the whole pool or that moves the round-robin pointer on a cycle with no issue.

// File: rtl/wis_pkg.sv
package wis_pkg;
    typedef enum logic [2:0] {
        CLS_FP32 = 3'd0,
        CLS_IMAD = 3'd1,
        CLS_PAIR = 3'd2,
        CLS_MMA  = 3'd3,
        CLS_VAR  = 3'd4
    } op_cls_e;

    localparam int DISP_W  = 4;
    localparam int D_HEAVY = 0;
    localparam int D_LIGHT = 1;
    localparam int D_MMA   = 2;
    localparam int D_VQ    = 3;
endpackage

// File: rtl/wis_pipe_busy.sv
module wis_pipe_busy #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] hold,
    output logic          free
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = hold;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign free = (cnt_q == '0);
endmodule

// File: rtl/wis_rr_pick.sv
module wis_rr_pick #(
    parameter int N  = 8,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] last,
    output logic          hit,
    output logic [IW-1:0] idx
);
    int cand;

    always_comb begin
        hit  = 1'b0;
        idx  = last;
        cand = 0;
        for (int k = 1; k <= N; k++) begin
            cand = (int'(last) + k) % N;
            if (!hit && req[cand]) begin
                hit = 1'b1;
                idx = IW'(cand);
            end
        end
    end
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
    import wis_pkg::*;
#(
    parameter int NUM_WARPS   = 8,
    parameter int WARP_LANES  = 32,
    parameter int HEAVY_LANES = 16,
    parameter int LIGHT_LANES = 16,
    parameter int MMA_LANES   = 16,
    parameter bit SHARED_PORT = 1'b0,
    localparam int WW = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_WARPS-1:0]   warp_active,
    input  logic [NUM_WARPS-1:0]   warp_stall,
    input  logic [3*NUM_WARPS-1:0] warp_class,
    input  logic                   vq_full,
    output logic                   issue_valid,
    output logic [WW-1:0]          issue_warp,
    output logic [3:0]             disp
);
    localparam int H_BEATS  = WARP_LANES / HEAVY_LANES;
    localparam int L_BEATS  = WARP_LANES / LIGHT_LANES;
    localparam int M_BEATS  = WARP_LANES / MMA_LANES;
    localparam int P_BEATS  = (H_BEATS > L_BEATS) ? H_BEATS : L_BEATS;
    localparam int MAX_B    = (P_BEATS > M_BEATS) ? P_BEATS : M_BEATS;
    localparam int CW       = $clog2(MAX_B + 1);

    typedef struct packed {
        logic [WW-1:0] last;
    } st_t;

    st_t st_d, st_q;

    logic heavy_free, light_free, mma_free, port_free;
    logic ld_heavy, ld_light, ld_mma;
    logic [NUM_WARPS-1:0] elig;
    logic hit;
    logic [WW-1:0] pick;
    op_cls_e pick_cls;

    genvar gw;
    generate
        for (gw = 0; gw < NUM_WARPS; gw++) begin : g_elig
            op_cls_e c;
            logic    res_ok;
            assign c = op_cls_e'(warp_class[3*gw +: 3]);
            always_comb begin
                case (c)
                    CLS_FP32: res_ok = light_free | heavy_free;
                    CLS_IMAD: res_ok = heavy_free;
                    CLS_PAIR: res_ok = heavy_free & light_free & port_free;
                    CLS_MMA:  res_ok = mma_free & port_free;
                    CLS_VAR:  res_ok = ~vq_full;
                    default:  res_ok = 1'b0;
                endcase
            end
            assign elig[gw] = rst_n & warp_active[gw] & ~warp_stall[gw] & res_ok;
        end
    endgenerate

    wis_rr_pick #(.N(NUM_WARPS), .IW(WW)) u_pick (
        .req  (elig),
        .last (st_q.last),
        .hit  (hit),
        .idx  (pick)
    );

    assign pick_cls = op_cls_e'(warp_class[3*pick +: 3]);

    always_comb begin
        disp = '0;
        if (hit) begin
            case (pick_cls)
                CLS_FP32: begin
                    if (light_free) disp[D_LIGHT] = 1'b1;
                    else            disp[D_HEAVY] = 1'b1;
                end
                CLS_IMAD: disp[D_HEAVY] = 1'b1;
                CLS_PAIR: begin
                    disp[D_HEAVY] = 1'b1;
                    disp[D_LIGHT] = 1'b1;
                end
                CLS_MMA:  disp[D_MMA] = 1'b1;
                CLS_VAR:  disp[D_VQ]  = 1'b1;
                default:  disp = '0;
            endcase
        end
        ld_heavy = disp[D_HEAVY];
        ld_light = disp[D_LIGHT];
        ld_mma   = disp[D_MMA];
        st_d      = st_q;
        if (hit) st_d.last = pick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{last: WW'(NUM_WARPS - 1)};
        else        st_q <= st_d;
    end

    assign issue_valid = hit;
    assign issue_warp  = pick;

    wis_pipe_busy #(.CW(CW)) u_heavy (
        .clk(clk), .rst_n(rst_n), .load(ld_heavy),
        .hold(CW'(H_BEATS - 1)), .free(heavy_free));
    wis_pipe_busy #(.CW(CW)) u_light (
        .clk(clk), .rst_n(rst_n), .load(ld_light),
        .hold(CW'(L_BEATS - 1)), .free(light_free));
    wis_pipe_busy #(.CW(CW)) u_mma (
        .clk(clk), .rst_n(rst_n), .load(ld_mma),
        .hold(CW'(M_BEATS - 1)), .free(mma_free));

    generate
        if (SHARED_PORT) begin : g_port
            logic          port_ld;
            logic [CW-1:0] port_hold;
            assign port_ld   = hit & ((pick_cls == CLS_PAIR) | (pick_cls == CLS_MMA));
            assign port_hold = (pick_cls == CLS_MMA) ? CW'(M_BEATS - 1) : CW'(P_BEATS - 1);
            wis_pipe_busy #(.CW(CW)) u_port (
                .clk(clk), .rst_n(rst_n), .load(port_ld),
                .hold(port_hold), .free(port_free));
        end else begin : g_noport
            assign port_free = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/wis_checker.sv
module wis_checker #(
    parameter int NUM_WARPS   = 8,
    parameter int WARP_LANES  = 32,
    parameter int HEAVY_LANES = 16,
    parameter int MMA_LANES   = 16,
    parameter bit SHARED_PORT = 1'b0,
    parameter int WW          = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_WARPS-1:0]   warp_active,
    input logic [NUM_WARPS-1:0]   warp_stall,
    input logic [3*NUM_WARPS-1:0] warp_class,
    input logic                   vq_full,
    input logic                   issue_valid,
    input logic [WW-1:0]          issue_warp,
    input logic [3:0]             disp
);
    logic [2:0] cls;
    assign cls = warp_class[3*issue_warp +: 3];

    assert_legal_warp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (warp_active[issue_warp] && !warp_stall[issue_warp]));
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |-> (disp == 4'b0000));
    assert_fp32_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && cls == 3'd0) |-> (disp == 4'b0010 || disp == 4'b0001));
    assert_imad_heavy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && cls == 3'd1) |-> (disp == 4'b0001));
    assert_pair_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && cls == 3'd2) |-> (disp == 4'b0011));
    assert_mma_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && cls == 3'd3) |-> (disp == 4'b0100));
    assert_vq_room_R6: assert property (@(posedge clk) disable iff (!rst_n)
        disp[3] |-> !vq_full);
    assert_bad_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (cls <= 3'd4));
    assert_reset_quiet_R12: assert property (@(posedge clk)
        !rst_n |-> (!issue_valid && disp == 4'b0000));

    generate
        if (WARP_LANES / HEAVY_LANES > 1) begin : g_hb
            assert_heavy_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
                disp[0] |=> !disp[0]);
        end
        if (SHARED_PORT && (WARP_LANES / MMA_LANES > 1)) begin : g_sp
            assert_port_shared_R10: assert property (@(posedge clk) disable iff (!rst_n)
                disp[2] |=> (disp[1:0] != 2'b11));
        end
    endgenerate
endmodule

bind warp_issue_sched wis_checker #(
    .NUM_WARPS(NUM_WARPS), .WARP_LANES(WARP_LANES), .HEAVY_LANES(HEAVY_LANES),
    .MMA_LANES(MMA_LANES), .SHARED_PORT(SHARED_PORT), .WW(WW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .warp_active(warp_active), .warp_stall(warp_stall),
    .warp_class(warp_class), .vq_full(vq_full), .issue_valid(issue_valid),
    .issue_warp(issue_warp), .disp(disp)
);

// File: tb/sim_warp_issue_sched.sv
`timescale 1ns/1ps
module sim_warp_issue_sched;
    localparam int NW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NW-1:0] act_v, stl_v;
    logic [3*NW-1:0] cls_v;
    logic vqf;
    logic v0, v1;
    logic [2:0] w0, w1;
    logic [3:0] d0, d1;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int act[NW], stl[NW], cls[NW];
    int hb[2], lb[2], mb[2], pb[2], ptr[2];

    always #2 clk = ~clk;

    warp_issue_sched #(.NUM_WARPS(NW), .WARP_LANES(32), .HEAVY_LANES(16),
        .LIGHT_LANES(16), .MMA_LANES(16), .SHARED_PORT(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .warp_active(act_v), .warp_stall(stl_v),
        .warp_class(cls_v), .vq_full(vqf), .issue_valid(v0), .issue_warp(w0), .disp(d0));

    warp_issue_sched #(.NUM_WARPS(NW), .WARP_LANES(32), .HEAVY_LANES(16),
        .LIGHT_LANES(16), .MMA_LANES(16), .SHARED_PORT(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .warp_active(act_v), .warp_stall(stl_v),
        .warp_class(cls_v), .vq_full(vqf), .issue_valid(v1), .issue_warp(w1), .disp(d1));

    task automatic drive();
        for (int i = 0; i < NW; i++) begin
            act_v[i] = act[i][0];
            stl_v[i] = stl[i][0];
            cls_v[3*i +: 3] = 3'(cls[i]);
        end
    endtask

    function automatic bit can_go(int m, int c);
        case (c)
            0: return (lb[m] == 0) || (hb[m] == 0);
            1: return hb[m] == 0;
            2: return (hb[m] == 0) && (lb[m] == 0) && (m == 0 || pb[m] == 0);
            3: return (mb[m] == 0) && (m == 0 || pb[m] == 0);
            4: return !vqf;
            default: return 0;
        endcase
    endfunction

    task automatic model(int m, output bit ev, output int ew, output int ed);
        ev = 0; ew = 0; ed = 0;
        if (!rst_n) return;
        for (int k = 1; k <= NW; k++) begin
            int c;
            c = (ptr[m] + k) % NW;
            if (!ev && act[c] != 0 && stl[c] == 0 && can_go(m, cls[c])) begin
                ev = 1; ew = c;
            end
        end
        if (ev) begin
            case (cls[ew])
                0: ed = (lb[m] == 0) ? 2 : 1;
                1: ed = 1;
                2: ed = 3;
                3: ed = 4;
                default: ed = 8;
            endcase
        end
    endtask

    task automatic advance(int m, bit ev, int ew, int ed);
        if (!rst_n) begin
            hb[m] = 0; lb[m] = 0; mb[m] = 0; pb[m] = 0; ptr[m] = NW - 1;
            return;
        end
        if (hb[m] > 0) hb[m]--;
        if (lb[m] > 0) lb[m]--;
        if (mb[m] > 0) mb[m]--;
        if (pb[m] > 0) pb[m]--;
        if (ev) begin
            ptr[m] = ew;
            if (ed[0]) hb[m] = 1;
            if (ed[1]) lb[m] = 1;
            if (ed[2]) mb[m] = 1;
            if (m == 1 && (cls[ew] == 2 || cls[ew] == 3)) pb[m] = 1;
        end
    endtask

    function automatic string tag_of(int c, bit ev);
        if (!ev) return "R1";
        case (c)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(string tag, string what, int a, int e);
        checks++;
        if (a != e) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, a, e, $time);
        end
    endtask

    task automatic cyc(string tag);
        bit ev[2];
        int ew[2], ed[2];
        string t;
        #1;
        for (int m = 0; m < 2; m++) begin
            model(m, ev[m], ew[m], ed[m]);
            t = (tag != "") ? tag : tag_of(ev[m] ? cls[ew[m]] : 0, ev[m]);
            if (m == 0) begin
                chk(t, "u0 valid", int'(v0), int'(ev[m]));
                chk(t, "u0 disp", int'(d0), ed[m]);
                if (ev[m]) chk(t, "u0 warp", int'(w0), ew[m]);
            end else begin
                chk(t, "u1 valid", int'(v1), int'(ev[m]));
                chk(t, "u1 disp", int'(d1), ed[m]);
                if (ev[m]) chk(t, "u1 warp", int'(w1), ew[m]);
            end
        end
        @(posedge clk);
        for (int m = 0; m < 2; m++) advance(m, ev[m], ew[m], ed[m]);
        @(negedge clk);
    endtask

    task automatic idle_all();
        for (int i = 0; i < NW; i++) begin
            act[i] = 0; stl[i] = 0; cls[i] = 0;
        end
        vqf = 1'b0;
    endtask

    initial begin
        idle_all();
        for (int i = 0; i < NW; i++) act[i] = 1;
        drive();
        for (int m = 0; m < 2; m++) advance(m, 0, 0, 0);
        @(negedge clk);
        cyc("R12");
        cyc("R12");
        rst_n = 1'b1;

        idle_all();
        act[0] = 1; cls[0] = 1; act[1] = 1; cls[1] = 3; drive();
        cyc("R9");
        cyc("R11");
        cyc("R7");
        cyc("R8");
        cyc("R7");

        idle_all();
        act[0] = 1; cls[0] = 2; act[1] = 1; cls[1] = 3; drive();
        for (int i = 0; i < 6; i++) cyc("R10");

        idle_all();
        for (int i = 0; i < NW; i++) act[i] = 1;
        drive();
        for (int i = 0; i < 8; i++) cyc("R2");

        idle_all();
        act[0] = 1; cls[0] = 4; act[1] = 1; cls[1] = 1; vqf = 1'b1; drive();
        cyc("R6"); cyc("R8"); cyc("R6");
        vqf = 1'b0; drive();
        cyc("R6");
        act[2] = 1; cls[2] = 6; drive();
        cyc("R6"); cyc("R6");

        for (int n = 0; n < 4000; n++) begin
            for (int i = 0; i < NW; i++) begin
                act[i] = ($urandom % 4) != 0;
                stl[i] = ($urandom % 5) == 0;
                cls[i] = $urandom % 6;
            end
            vqf = ($urandom % 3) == 0;
            drive();
            cyc("");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule